// File: doc/BRIEF.md
# Half-Duplex Converter Data Port Controller

This block is the digital side of a time-division-duplex converter. A single data bus is shared between a wide transmit path, which feeds a DAC, and a narrower receive path, which comes from an ADC. Two enable pins choose what the port does. It can be in receive mode, where it drives the lower bus bits with captured ADC codes. It can be in transmit mode, where it takes DAC words from the whole bus through a master/slave register. When both enables are equal it is in a quiet shutdown state, and it stays there even if the clock keeps running.

Incoming data is always taken on the falling clock edge and presented on the following rising edge. Mode changes take effect at a rising edge. Every output update is marked by a one-cycle strobe, so the surrounding logic or a bench can compare the word it expects with the word applied. All codes are two's-complement and pass through unchanged. The analog conversion is not modelled: receive samples enter as digital codes on `adc_code`.

Top module: `tdd_port_ctrl`

## Requirements
- R1: `mode` reads 2'b01 (receive) when `rx_en`=1 and `tx_en`=0, and 2'b10 (transmit) when `tx_en`=1 and `rx_en`=0. It reads 2'b00 (shutdown) when the two enables are equal. A change of the enables shows on `mode` after the next rising clock edge.
- R2: `bus_oe` is 1 only in receive mode. In receive mode bus bits 4..0 carry the receive word. Bus bits 6..5 are never driven by the block.
- R3: In transmit mode the value on bus bits 6..0 at a falling edge appears on `dac_word` after the next rising edge. A bus change after that falling edge has no effect on that update. Between updates `dac_word` holds its value.
- R4: In receive mode, `adc_code` is sampled at a falling edge and appears on bus bits 4..0 after the next rising edge. A change of `adc_code` after that falling edge has no effect on that update.
- R5: Codes pass through unchanged. This covers the transmit codes 7'h3F (positive full scale), 7'h00 (zero) and 7'h40 (negative full scale), and the receive codes 5'h0F (most positive) and 5'h10 (most negative).
- R6: In shutdown (enables 00 or 11) the block drives no bus bit, produces no strobe, holds both valid flags low, and ignores changes on `adc_code`.
- R7: When the block leaves transmit mode, `dac_word` is cleared to 7'h00, the mid-scale code. It stays 7'h00 until the next transmit update.
- R8: `dac_valid` and `rx_valid` stay low after a mode is entered until the first rising-edge update in that mode. They are never high together.
- R9: A transmit word latched on the falling edge just before a mode switch is discarded. It never reaches `dac_word`.
- R10: `upd_strobe` is high for the one cycle after each rising-edge update of `dac_word` or of the receive word, including an update that repeats the same value. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock; capture on falling edge, update on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| tx_en | input | 1 | Transmit enable |
| adc_code | input | RX_W (5) | Two's-complement receive sample from the converter |
| bus | inout | TX_W (7) | Shared data bus; transmit input on all bits, receive output on low RX_W bits |
| bus_oe | output | 1 | Block is driving the low bus bits |
| mode | output | 2 | 00 shutdown, 01 receive, 10 transmit |
| dac_word | output | TX_W (7) | Word applied to the DAC |
| dac_valid | output | 1 | `dac_word` holds a word taken in the current transmit period |
| rx_valid | output | 1 | Bus carries a code sampled in the current receive period |
| upd_strobe | output | 1 | One-cycle pulse after each output update |

## Verification
The bench builds the block with its default values: a 7-bit transmit word, a 5-bit receive code, and clear-on-idle enabled. These widths put the positive and negative full-scale codes of both paths within reach. They also leave two upper bus bits that the block must never drive, and they make the mid-scale clear of R7 visible when leaving transmit. The tests change inputs just after a falling edge to show the half-cycle capture. They also switch modes one edge after a word is latched, which exercises the discard path.

// File: rtl/tdd_port_pkg.sv
package tdd_port_pkg;

   typedef enum logic [1:0] {
      PORT_OFF = 2'b00,
      PORT_RX  = 2'b01,
      PORT_TX  = 2'b10
   } port_mode_e;

   function automatic port_mode_e decode_mode(input logic rx_en, input logic tx_en);
      port_mode_e m;
      if (rx_en && !tx_en)
         m = PORT_RX;
      else if (tx_en && !rx_en)
         m = PORT_TX;
      else
         m = PORT_OFF;
      return m;
   endfunction

endpackage

// File: rtl/tdd_mode_ctrl.sv
module tdd_mode_ctrl
   import tdd_port_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_en,
   input  logic       tx_en,
   output port_mode_e mode_nxt,
   output port_mode_e mode_q,
   output logic       arm_tx,
   output logic       arm_rx
);

   assign mode_nxt = decode_mode(rx_en, tx_en);

   // mode register: pin changes land at the rising edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= PORT_OFF;
      else
         mode_q <= mode_nxt;
   end

   // falling-edge arm: a capture only counts when the active mode and
   // the pins agree, so a word taken across a switch is never applied
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_tx <= 1'b0;
         arm_rx <= 1'b0;
      end else begin
         arm_tx <= (mode_q == PORT_TX) && (mode_nxt == PORT_TX);
         arm_rx <= (mode_q == PORT_RX) && (mode_nxt == PORT_RX);
      end
   end

endmodule

// File: rtl/tdd_ms_stage.sv
module tdd_ms_stage #(
   parameter int W             = 7,
   parameter bit CLEAR_ON_IDLE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap_en,
   input  logic         arm,
   input  logic         live,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         valid,
   output logic         upd
);

   localparam logic [W-1:0] MID_CODE = '0;

   logic [W-1:0] master;

   // master half: falling-edge capture
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         master <= MID_CODE;
      else if (cap_en)
         master <= d;
   end

   assign upd = arm && live;

   // slave half: rising-edge update, variant picked by parameter
   generate
      if (CLEAR_ON_IDLE) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q     <= MID_CODE;
               valid <= 1'b0;
            end else if (!live) begin
               q     <= MID_CODE;
               valid <= 1'b0;
            end else if (upd) begin
               q     <= master;
               valid <= 1'b1;
            end
         end
      end else begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q     <= MID_CODE;
               valid <= 1'b0;
            end else if (!live) begin
               valid <= 1'b0;
            end else if (upd) begin
               q     <= master;
               valid <= 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tdd_bus_io.sv
module tdd_bus_io #(
   parameter int TX_W = 7,
   parameter int RX_W = 5
) (
   inout  wire logic [TX_W-1:0] pad,
   input  logic                 oe,
   input  logic [RX_W-1:0]      drv,
   output logic [TX_W-1:0]      rd
);

   generate
      for (genvar i = 0; i < TX_W; i++) begin : g_bit
         if (i < RX_W) begin : g_shared
            assign pad[i] = oe ? drv[i] : 1'bz;
         end else begin : g_inonly
            assign pad[i] = 1'bz;
         end
      end
   endgenerate

   assign rd = pad;

endmodule

// File: rtl/tdd_port_ctrl.sv
module tdd_port_ctrl
   import tdd_port_pkg::*;
#(
   parameter int TX_W          = 7,
   parameter int RX_W          = 5,
   parameter bit CLEAR_ON_IDLE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_en,
   input  logic            tx_en,
   input  logic [RX_W-1:0] adc_code,
   inout  wire logic [TX_W-1:0] bus,
   output logic            bus_oe,
   output logic [1:0]      mode,
   output logic [TX_W-1:0] dac_word,
   output logic            dac_valid,
   output logic            rx_valid,
   output logic            upd_strobe
);

   generate
      if (RX_W < 1 || RX_W >= TX_W) begin : g_bad_width
         $error("tdd_port_ctrl: RX_W must be at least 1 and below TX_W");
      end
   endgenerate

   port_mode_e      mode_nxt;
   port_mode_e      mode_q;
   logic            arm_tx;
   logic            arm_rx;
   logic            upd_tx;
   logic            upd_rx;
   logic [TX_W-1:0] bus_rd;
   logic [RX_W-1:0] rx_word;

   tdd_mode_ctrl u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_en    (rx_en),
      .tx_en    (tx_en),
      .mode_nxt (mode_nxt),
      .mode_q   (mode_q),
      .arm_tx   (arm_tx),
      .arm_rx   (arm_rx)
   );

   tdd_ms_stage #(.W(TX_W), .CLEAR_ON_IDLE(CLEAR_ON_IDLE)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (mode_q == PORT_TX),
      .arm    (arm_tx),
      .live   (mode_nxt == PORT_TX),
      .d      (bus_rd),
      .q      (dac_word),
      .valid  (dac_valid),
      .upd    (upd_tx)
   );

   tdd_ms_stage #(.W(RX_W), .CLEAR_ON_IDLE(1'b1)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (mode_q == PORT_RX),
      .arm    (arm_rx),
      .live   (mode_nxt == PORT_RX),
      .d      (adc_code),
      .q      (rx_word),
      .valid  (rx_valid),
      .upd    (upd_rx)
   );

   assign bus_oe = (mode_q == PORT_RX);

   tdd_bus_io #(.TX_W(TX_W), .RX_W(RX_W)) u_io (
      .pad (bus),
      .oe  (bus_oe),
      .drv (rx_word),
      .rd  (bus_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         upd_strobe <= 1'b0;
      else
         upd_strobe <= upd_tx || upd_rx;
   end

   assign mode = mode_q;

endmodule

// File: rtl/tdd_port_ctrl_chk.sv
module tdd_port_ctrl_chk #(
   parameter int TX_W = 7
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rx_en,
   input logic            tx_en,
   input logic [1:0]      mode,
   input logic            bus_oe,
   input logic [TX_W-1:0] dac_word,
   input logic            dac_valid,
   input logic            rx_valid,
   input logic            upd_strobe
);

   // R1
   rx_mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && !tx_en) |=> (mode == 2'b01));

   // R1
   tx_mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !rx_en) |=> (mode == 2'b10));

   // R2
   oe_rx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> (mode == 2'b01));

   // R6
   shutdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |-> (!bus_oe && !upd_strobe && !dac_valid && !rx_valid));

   // R3
   dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == 2'b10) && !upd_strobe) |-> $stable(dac_word));

   // R8
   valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dac_valid, rx_valid}));

   // R10
   strobe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_strobe |-> (dac_valid || rx_valid));

endmodule

bind tdd_port_ctrl tdd_port_ctrl_chk #(.TX_W(TX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_en      (rx_en),
   .tx_en      (tx_en),
   .mode       (mode),
   .bus_oe     (bus_oe),
   .dac_word   (dac_word),
   .dac_valid  (dac_valid),
   .rx_valid   (rx_valid),
   .upd_strobe (upd_strobe)
);

// File: tb/tdd_port_ctrl_test.sv
module tdd_port_ctrl_test;

   localparam int TX_W = 7;
   localparam int RX_W = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            rx_en = 1'b0;
   logic            tx_en = 1'b0;
   logic [RX_W-1:0] adc_code = '0;
   logic [TX_W-1:0] tb_drv = '0;
   logic            tb_oe = 1'b0;
   wire  [TX_W-1:0] bus;
   logic            bus_oe;
   logic [1:0]      mode;
   logic [TX_W-1:0] dac_word;
   logic            dac_valid;
   logic            rx_valid;
   logic            upd_strobe;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   assign bus = tb_oe ? tb_drv : {TX_W{1'bz}};

   always #2 clk = ~clk;

   tdd_port_ctrl #(.TX_W(TX_W), .RX_W(RX_W)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_en      (rx_en),
      .tx_en      (tx_en),
      .adc_code   (adc_code),
      .bus        (bus),
      .bus_oe     (bus_oe),
      .mode       (mode),
      .dac_word   (dac_word),
      .dac_valid  (dac_valid),
      .rx_valid   (rx_valid),
      .upd_strobe (upd_strobe)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      check(mode == 2'b00, "R1 reset mode", mode, 0);
      check(bus_oe == 1'b0, "R2 reset oe", bus_oe, 0);
      check(dac_word == 7'h00, "R7 reset dac_word", dac_word, 0);
      check(upd_strobe == 1'b0, "R10 reset strobe", upd_strobe, 0);
      check(!dac_valid && !rx_valid, "R8 reset valid", {dac_valid, rx_valid}, 0);
   endtask

   task automatic t_tx_basic();
      tx_en = 1'b1; rx_en = 1'b0;
      tb_oe = 1'b1; tb_drv = 7'h3F;
      step();
      check(mode == 2'b10, "R1 tx mode", mode, 2);
      check(dac_valid == 1'b0, "R8 tx valid before update", dac_valid, 0);
      check(upd_strobe == 1'b0, "R10 no strobe on entry", upd_strobe, 0);
      check(bus_oe == 1'b0, "R2 oe low in tx", bus_oe, 0);
      step();
      check(dac_word == 7'h3F, "R5 +FS code", dac_word, 7'h3F);
      check(dac_valid == 1'b1, "R8 tx valid after update", dac_valid, 1);
      check(upd_strobe == 1'b1, "R10 strobe on tx update", upd_strobe, 1);
      tb_drv = 7'h40;
      step();
      check(dac_word == 7'h40, "R5 -FS code", dac_word, 7'h40);
      tb_drv = 7'h00;
      step();
      check(dac_word == 7'h00, "R5 zero code", dac_word, 0);
      step();
      check(upd_strobe == 1'b1, "R10 strobe on repeated word", upd_strobe, 1);
   endtask

   task automatic t_tx_half_cycle();
      tb_drv = 7'h2A;
      #2;
      tb_drv = 7'h11;
      step();
      check(dac_word == 7'h2A, "R3 falling-edge capture", dac_word, 7'h2A);
      step();
      check(dac_word == 7'h11, "R3 next word", dac_word, 7'h11);
   endtask

   task automatic t_tx_discard();
      tb_drv = 7'h05;
      tx_en = 1'b0;
      step();
      tb_oe = 1'b0;
      check(mode == 2'b00, "R1 tx to shutdown", mode, 0);
      check(dac_word == 7'h00, "R9 latched word discarded", dac_word, 0);
      check(upd_strobe == 1'b0, "R9 no strobe on switch", upd_strobe, 0);
      check(dac_valid == 1'b0, "R7 valid cleared", dac_valid, 0);
   endtask

   task automatic t_shutdown();
      rx_en = 1'b1; tx_en = 1'b1;
      step();
      check(mode == 2'b00, "R1 enables 11 shutdown", mode, 0);
      for (int i = 0; i < 4; i++) begin
         adc_code = 5'(i * 7 + 3);
         step();
         check(!bus_oe && !upd_strobe && !rx_valid, "R6 quiet in shutdown",
               {bus_oe, upd_strobe, rx_valid}, 0);
      end
      rx_en = 1'b0; tx_en = 1'b0;
      step();
      check(mode == 2'b00 && !bus_oe, "R6 enables 00 shutdown", {mode, bus_oe}, 0);
   endtask

   task automatic t_rx();
      rx_en = 1'b1; tx_en = 1'b0;
      adc_code = 5'h0F;
      step();
      check(mode == 2'b01, "R1 rx mode", mode, 1);
      check(bus_oe == 1'b1, "R2 oe in rx", bus_oe, 1);
      check(rx_valid == 1'b0, "R8 rx valid before update", rx_valid, 0);
      step();
      check(bus[4:0] == 5'h0F, "R5 rx +max code", bus[4:0], 5'h0F);
      check(rx_valid && upd_strobe, "R10 rx update strobe", {rx_valid, upd_strobe}, 3);
      check(dac_valid == 1'b0, "R8 dac_valid low in rx", dac_valid, 0);
      adc_code = 5'h10;
      #2;
      adc_code = 5'h03;
      step();
      check(bus[4:0] == 5'h10, "R4 rx falling-edge sample", bus[4:0], 5'h10);
      step();
      check(bus[4:0] == 5'h03, "R4 rx next sample", bus[4:0], 5'h03);
   endtask

   task automatic t_rx_to_tx();
      adc_code = 5'h07;
      rx_en = 1'b0; tx_en = 1'b1;
      step();
      check(mode == 2'b10 && !bus_oe, "R2 oe released on tx", {mode, bus_oe}, 2);
      check(!rx_valid && !upd_strobe, "R9 rx sample dropped", {rx_valid, upd_strobe}, 0);
      check(dac_word == 7'h00, "R7 mid-scale before tx update", dac_word, 0);
      tb_oe = 1'b1; tb_drv = 7'h55;
      step();
      check(dac_word == 7'h55, "R3 tx after rx", dac_word, 7'h55);
      tx_en = 1'b0; rx_en = 1'b1; tb_oe = 1'b0;
      step();
      check(dac_word == 7'h00, "R7 cleared leaving tx", dac_word, 0);
   endtask

   initial begin
      #9;
      rst_n = 1'b1;
      step();
      t_reset();
      t_tx_basic();
      t_tx_half_cycle();
      t_tx_discard();
      t_shutdown();
      t_rx();
      t_rx_to_tx();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule